// File: doc/BRIEF.md
# Ethernet Transmit Frame Encapsulator

This block turns a frame body held in a transmit byte buffer into the serial NRZ bit stream handed to a line encoder. Software writes the destination address, source address, length/type and payload into the buffer, then issues a command giving the body length, a start-threshold code, a pad-enable bit and an FCS-suppress bit. The buffer's written-byte count is presented to the block. Once that count satisfies the selected threshold and the medium-access logic asserts the transmit permit, the block sends the preamble, the start delimiter, the body, optional zero padding and an optional CRC-32 frame check sequence.

One bit leaves the block on every cycle in which the bit-enable strobe is high. Every byte goes out least-significant bit first. The buffer is read through an address/data port with combinational read data. If the buffer has not yet received a body byte when that byte is due, the frame is abandoned. The block does not handle collisions, backoff or line coding.

Top module: `eth_tx_framer`

## Requirements
- R1: After reset the block is idle: `txd_valid_o`, `done_o` and `underrun_o` stay low until a command is issued, even while `bit_en_i` is high.
- R2: A latched frame starts only in a cycle where `tx_permit_i` is high and the byte count meets the threshold code: 0 needs 5 bytes, 1 needs 381, 2 needs 1021, 3 needs the whole body. A count that already covers the whole body satisfies every code.
- R3: A frame opens with 7 bytes of value 0x55 and then the delimiter byte 0xD5. Sent LSB first, this is 56 bits alternating from 1, followed by 1,0,1,0,1,0,1,1.
- R4: After the delimiter, body bytes are read from buffer addresses 0 to length-1 in ascending order and sent LSB first. A bit is emitted only in a cycle where `bit_en_i` is high.
- R5: Unless suppressed, the last 32 bits are the complement of the reflected CRC-32 (polynomial 0x04C11DB7, preset all ones), computed over the body and pad bytes. Bit 0 is sent first.
- R6: With `cmd_nofcs_i` set, no FCS is sent. The frame ends after the last body or pad byte.
- R7: With `cmd_pad_i` set and a body shorter than 60 bytes, zero bytes are appended until the body and pad together reach 60 bytes, before any FCS. With the bit clear, or with a body of 60 bytes or more, nothing is appended.
- R8: If, in a cycle where body byte i is due and `bit_en_i` is high, the byte count is at most i, no bit is emitted. `underrun_o` then pulses for one cycle, no FCS follows, and the block returns to idle and accepts the next command.
- R9: `done_o` pulses for one cycle, in the cycle right after the final bit of a completed frame. It never pulses for an abandoned frame.
- R10: A command presented while a frame is pending or in progress is ignored. It neither changes that frame nor starts another afterwards.
- R11: Body lengths run from 1 to 1514 bytes (1518 with FCS suppressed). A 1514-byte body with FCS produces a 1518-byte frame after the delimiter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command strobe, taken only when idle |
| cmd_len_i | input | 11 | Body length in bytes |
| cmd_thr_i | input | 2 | Start-threshold code |
| cmd_pad_i | input | 1 | Pad short frames to 60 body bytes |
| cmd_nofcs_i | input | 1 | Suppress FCS generation |
| buf_count_i | input | 11 | Number of body bytes written to the buffer |
| buf_addr_o | output | 11 | Buffer read address |
| buf_data_i | input | 8 | Buffer read data for `buf_addr_o` (combinational) |
| tx_permit_i | input | 1 | Medium-access permit to start |
| bit_en_i | input | 1 | Bit-time strobe |
| txd_o | output | 1 | Serial data bit |
| txd_valid_o | output | 1 | Bit emitted this cycle |
| done_o | output | 1 | One-cycle pulse after a completed frame |
| underrun_o | output | 1 | One-cycle pulse when a frame is abandoned |

## Verification
The byte-boundary buffer check and the software's buffer writes can land in the same cycle. The case of interest is a count that reaches i+1 in exactly the cycle where byte i is due. The bench provokes this by dripping the count upward from the observed output, one byte just in time. The frame must complete with no underrun and with a bit-exact stream. Holding the count one byte short must instead produce the underrun pulse after exactly the bits sent so far.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_PRE, ST_SFD, ST_BODY, ST_PAD, ST_FCS
  } tx_st_e;

  localparam logic [7:0]  PRE_BYTE     = 8'h55;
  localparam logic [7:0]  SFD_BYTE     = 8'hD5;
  localparam logic [31:0] CRC_POLY_REF = 32'hEDB88320;
endpackage

// File: rtl/eth_tx_gate.sv
module eth_tx_gate #(
  parameter int CNT_W = 11,
  parameter int THR0  = 5,
  parameter int THR1  = 381,
  parameter int THR2  = 1021
) (
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic [1:0]       sel_i,
  output logic             met_o
);
  localparam int unsigned THR_TAB [3] = '{THR0, THR1, THR2};

  logic [3:0] ge;

  for (genvar i = 0; i < 4; i++) begin : g_thr
    if (i < 3) begin : g_cmp
      assign ge[i] = count_i >= CNT_W'(THR_TAB[i]);
    end else begin : g_full
      assign ge[i] = 1'b0;   // code 3: whole body only
    end
  end

  assign met_o = (count_i >= len_i) | ge[sel_i];
endmodule

// File: rtl/eth_tx_crc.sv
module eth_tx_crc
  import eth_tx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_i,
  input  logic upd_i,
  input  logic shift_i,
  input  logic bit_i,
  output logic fcs_bit_o
);
  logic [31:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q <= '1;
    end else if (init_i) begin
      crc_q <= '1;
    end else if (upd_i) begin
      crc_q <= (crc_q >> 1) ^ (CRC_POLY_REF & {32{crc_q[0] ^ bit_i}});
    end else if (shift_i) begin
      crc_q <= crc_q >> 1;
    end
  end

  assign fcs_bit_o = ~crc_q[0];

  // R5
  crc_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(init_i && (upd_i || shift_i)) && !(upd_i && shift_i));
endmodule

// File: rtl/eth_tx_seq.sv
module eth_tx_seq
  import eth_tx_pkg::*;
#(
  parameter int CNT_W     = 11,
  parameter int PRE_BYTES = 7,
  parameter int MIN_BODY  = 60,
  parameter int MAX_FRAME = 1518,
  parameter int FCS_BYTES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [CNT_W-1:0] cmd_len_i,
  input  logic [1:0]       cmd_thr_i,
  input  logic             cmd_pad_i,
  input  logic             cmd_nofcs_i,
  input  logic             start_ok_i,
  input  logic             tx_permit_i,
  input  logic             bit_en_i,
  input  logic [CNT_W-1:0] buf_count_i,
  output tx_st_e           st_o,
  output logic [2:0]       bit_idx_o,
  output logic [CNT_W-1:0] byte_idx_o,
  output logic [CNT_W-1:0] len_o,
  output logic [1:0]       thr_o,
  output logic             emit_o,
  output logic             crc_init_o,
  output logic             crc_upd_o,
  output logic             crc_shift_o,
  output logic             done_o,
  output logic             underrun_o
);
  localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(PRE_BYTES - 1);
  localparam logic [CNT_W-1:0] MIN_C    = CNT_W'(MIN_BODY);
  localparam logic [CNT_W-1:0] FCS_LAST = CNT_W'(FCS_BYTES - 1);
  localparam logic [CNT_W-1:0] BODY_MAX = CNT_W'(MAX_FRAME - FCS_BYTES);
  localparam logic [CNT_W-1:0] RAW_MAX  = CNT_W'(MAX_FRAME);

  tx_st_e           st_q;
  logic [2:0]       bit_q;
  logic [CNT_W-1:0] cnt_q, len_q, n_c;
  logic [1:0]       thr_q;
  logic             pad_q, nofcs_q, done_q, urun_q;
  logic             sending, starve, emit, go;
  tx_st_e           tail_st;
  logic             tail_fin;

  assign sending = (st_q != ST_IDLE) && (st_q != ST_WAIT);
  // body byte due but not yet written
  assign starve  = (st_q == ST_BODY) && (bit_q == 3'd0) && (buf_count_i <= cnt_q);
  assign emit    = bit_en_i && sending && !starve;
  assign go      = (st_q == ST_WAIT) && start_ok_i && tx_permit_i;
  assign n_c     = cnt_q + 1'b1;

  // what follows the last body byte
  always_comb begin
    tail_st  = ST_IDLE;
    tail_fin = 1'b0;
    if (pad_q && (n_c < MIN_C)) tail_st = ST_PAD;
    else if (!nofcs_q)          tail_st = ST_FCS;
    else                        tail_fin = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      bit_q   <= '0;
      cnt_q   <= '0;
      len_q   <= '0;
      thr_q   <= '0;
      pad_q   <= 1'b0;
      nofcs_q <= 1'b0;
      done_q  <= 1'b0;
      urun_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      urun_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (cmd_valid_i) begin
            len_q   <= cmd_len_i;
            thr_q   <= cmd_thr_i;
            pad_q   <= cmd_pad_i;
            nofcs_q <= cmd_nofcs_i;
            st_q    <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (go) begin
            st_q  <= ST_PRE;
            cnt_q <= '0;
            bit_q <= '0;
          end
        end
        default: begin
          if (bit_en_i && starve) begin
            st_q   <= ST_IDLE;
            urun_q <= 1'b1;
          end else if (emit) begin
            bit_q <= bit_q + 3'd1;
            if (bit_q == 3'd7) begin
              case (st_q)
                ST_PRE: begin
                  if (cnt_q == PRE_LAST) begin
                    st_q  <= ST_SFD;
                    cnt_q <= '0;
                  end else cnt_q <= n_c;
                end
                ST_SFD: begin
                  st_q  <= ST_BODY;
                  cnt_q <= '0;
                end
                ST_BODY: begin
                  if (n_c == len_q) begin
                    st_q   <= tail_st;
                    done_q <= tail_fin;
                    cnt_q  <= (tail_st == ST_PAD) ? n_c : '0;
                  end else cnt_q <= n_c;
                end
                ST_PAD: begin
                  if (n_c == MIN_C) begin
                    st_q   <= nofcs_q ? ST_IDLE : ST_FCS;
                    done_q <= nofcs_q;
                    cnt_q  <= '0;
                  end else cnt_q <= n_c;
                end
                ST_FCS: begin
                  if (cnt_q == FCS_LAST) begin
                    st_q   <= ST_IDLE;
                    done_q <= 1'b1;
                  end else cnt_q <= n_c;
                end
                default: st_q <= ST_IDLE;
              endcase
            end
          end
        end
      endcase
    end
  end

  assign st_o        = st_q;
  assign bit_idx_o   = bit_q;
  assign byte_idx_o  = cnt_q;
  assign len_o       = len_q;
  assign thr_o       = thr_q;
  assign emit_o      = emit;
  assign crc_init_o  = go;
  assign crc_upd_o   = emit && ((st_q == ST_BODY) || (st_q == ST_PAD));
  assign crc_shift_o = emit && (st_q == ST_FCS);
  assign done_o      = done_q;
  assign underrun_o  = urun_q;

  // R2
  start_permit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PRE && $past(st_q) == ST_WAIT) |-> $past(tx_permit_i));
  // R3
  pre_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SFD && $past(st_q) == ST_PRE) |-> $past(cnt_q) == PRE_LAST);
  // R6
  no_fcs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nofcs_q |-> st_q != ST_FCS);
  // R7
  pad_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PAD) |-> (pad_q && cnt_q < MIN_C));
  // R8
  urun_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |-> ($past(st_q) == ST_BODY && st_q != ST_FCS));
  // R9
  done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && underrun_o));
  // R10
  cmd_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE && cmd_valid_i) |=> $stable(len_q));
  // R11
  len_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && cmd_valid_i) |->
      (cmd_len_i != '0 && cmd_len_i <= (cmd_nofcs_i ? RAW_MAX : BODY_MAX)));
endmodule

// File: rtl/eth_tx_framer.sv
module eth_tx_framer
  import eth_tx_pkg::*;
#(
  parameter int CNT_W     = 11,
  parameter int PRE_BYTES = 7,
  parameter int MIN_BODY  = 60,
  parameter int MAX_FRAME = 1518,
  parameter int THR0      = 5,
  parameter int THR1      = 381,
  parameter int THR2      = 1021
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [CNT_W-1:0] cmd_len_i,
  input  logic [1:0]       cmd_thr_i,
  input  logic             cmd_pad_i,
  input  logic             cmd_nofcs_i,
  input  logic [CNT_W-1:0] buf_count_i,
  output logic [CNT_W-1:0] buf_addr_o,
  input  logic [7:0]       buf_data_i,
  input  logic             tx_permit_i,
  input  logic             bit_en_i,
  output logic             txd_o,
  output logic             txd_valid_o,
  output logic             done_o,
  output logic             underrun_o
);
  tx_st_e           st;
  logic [2:0]       bit_idx;
  logic [CNT_W-1:0] byte_idx, len_l;
  logic [1:0]       thr_l;
  logic             met, emit, crc_init, crc_upd, crc_shift, fcs_bit;
  logic [7:0]       cur_byte;
  logic             cur_bit;

  eth_tx_gate #(
    .CNT_W(CNT_W), .THR0(THR0), .THR1(THR1), .THR2(THR2)
  ) u_gate (
    .count_i(buf_count_i),
    .len_i  (len_l),
    .sel_i  (thr_l),
    .met_o  (met)
  );

  eth_tx_seq #(
    .CNT_W(CNT_W), .PRE_BYTES(PRE_BYTES), .MIN_BODY(MIN_BODY),
    .MAX_FRAME(MAX_FRAME), .FCS_BYTES(4)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_valid_i(cmd_valid_i),
    .cmd_len_i  (cmd_len_i),
    .cmd_thr_i  (cmd_thr_i),
    .cmd_pad_i  (cmd_pad_i),
    .cmd_nofcs_i(cmd_nofcs_i),
    .start_ok_i (met),
    .tx_permit_i(tx_permit_i),
    .bit_en_i   (bit_en_i),
    .buf_count_i(buf_count_i),
    .st_o       (st),
    .bit_idx_o  (bit_idx),
    .byte_idx_o (byte_idx),
    .len_o      (len_l),
    .thr_o      (thr_l),
    .emit_o     (emit),
    .crc_init_o (crc_init),
    .crc_upd_o  (crc_upd),
    .crc_shift_o(crc_shift),
    .done_o     (done_o),
    .underrun_o (underrun_o)
  );

  eth_tx_crc u_crc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .init_i   (crc_init),
    .upd_i    (crc_upd),
    .shift_i  (crc_shift),
    .bit_i    (cur_bit),
    .fcs_bit_o(fcs_bit)
  );

  always_comb begin
    case (st)
      ST_PRE:  cur_byte = PRE_BYTE;
      ST_SFD:  cur_byte = SFD_BYTE;
      ST_BODY: cur_byte = buf_data_i;
      default: cur_byte = 8'h00;   // pad
    endcase
  end

  assign cur_bit     = (st == ST_FCS) ? fcs_bit : cur_byte[bit_idx];
  assign buf_addr_o  = byte_idx;
  assign txd_valid_o = emit;
  assign txd_o       = emit & cur_bit;

  // R9
  done_after_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(txd_valid_o));
  // R4
  en_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |-> !txd_valid_o);
endmodule

// File: tb/eth_tx_framer_tb.sv
module eth_tx_framer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [CW-1:0] cmd_len = '0;
  logic [1:0]    cmd_thr = '0;
  logic          cmd_pad = 1'b0;
  logic          cmd_nofcs = 1'b0;
  logic [CW-1:0] buf_count = '0;
  logic [CW-1:0] buf_addr;
  logic [7:0]    buf_data;
  logic          permit = 1'b0;
  logic          bit_en = 1'b0;
  logic          txd, txd_valid, done, urun;

  logic [7:0] mem [0:2047];
  assign buf_data = mem[buf_addr];

  eth_tx_framer u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_len_i(cmd_len), .cmd_thr_i(cmd_thr),
    .cmd_pad_i(cmd_pad), .cmd_nofcs_i(cmd_nofcs),
    .buf_count_i(buf_count), .buf_addr_o(buf_addr), .buf_data_i(buf_data),
    .tx_permit_i(permit), .bit_en_i(bit_en),
    .txd_o(txd), .txd_valid_o(txd_valid), .done_o(done), .underrun_o(urun)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  int cyc = 0;
  bit got_q[$];
  bit exp_q[$];
  int done_cnt, urun_cnt, en_viol, last_bit_cyc, done_cyc;
  int en_mode = 0, en_tick = 0, drip = 0, len_cur = 0;
  logic [31:0] crc_acc;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (txd_valid) begin
      got_q.push_back(txd);
      last_bit_cyc = cyc;
      if (!bit_en) en_viol++;
    end
    if (done) begin done_cnt++; done_cyc = cyc; end
    if (urun) urun_cnt++;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    int nc;
    @(posedge clk); #1;
    en_tick++;
    bit_en = (en_mode == 0) ? 1'b1 : en_tick[0];
    if (drip != 0 && got_q.size() >= 64) begin
      nc = (got_q.size() - 64) / 8 + 1;
      if (nc > len_cur) nc = len_cur;
      if (nc > int'(buf_count)) buf_count = CW'(nc);
    end
  endtask

  task automatic clear_obs();
    got_q.delete();
    done_cnt = 0; urun_cnt = 0; en_viol = 0;
    last_bit_cyc = -1; done_cyc = -2;
  endtask

  task automatic fill(input int len, input int seed);
    for (int i = 0; i < len; i++) mem[i] = 8'((i * 7) + (seed * 13) + 1);
  endtask

  task automatic push_byte(input logic [7:0] b, input bit in_crc);
    for (int k = 0; k < 8; k++) begin
      exp_q.push_back(b[k]);
      if (in_crc) begin
        if (crc_acc[0] ^ b[k]) crc_acc = (crc_acc >> 1) ^ 32'hEDB88320;
        else                   crc_acc = crc_acc >> 1;
      end
    end
  endtask

  task automatic build_exp(input int len, input bit pad, input bit nofcs);
    logic [31:0] f;
    exp_q.delete();
    crc_acc = '1;
    for (int i = 0; i < 7; i++) push_byte(8'h55, 1'b0);
    push_byte(8'hD5, 1'b0);
    for (int i = 0; i < len; i++) push_byte(mem[i], 1'b1);
    if (pad) for (int i = len; i < 60; i++) push_byte(8'h00, 1'b1);
    if (!nofcs) begin
      f = ~crc_acc;
      for (int k = 0; k < 32; k++) exp_q.push_back(f[k]);
    end
  endtask

  task automatic issue(input int len, input int thr, input bit pad, input bit nofcs);
    len_cur   = len;
    cmd_len   = CW'(len);
    cmd_thr   = 2'(thr);
    cmd_pad   = pad;
    cmd_nofcs = nofcs;
    cmd_valid = 1'b1;
    step();
    cmd_valid = 1'b0;
  endtask

  task automatic wait_end(input string req, input int limit);
    int n = 0;
    while (done_cnt == 0 && urun_cnt == 0 && n < limit) begin step(); n++; end
    check(n < limit, req, "frame end timeout", n, limit);
    repeat (3) step();
  endtask

  task automatic compare(input string req, input int nbits);
    int mism = 0;
    int lim;
    check(got_q.size() == nbits, req, "bit count", got_q.size(), nbits);
    lim = (got_q.size() < nbits) ? got_q.size() : nbits;
    for (int i = 0; i < lim; i++) if (got_q[i] != exp_q[i]) mism++;
    check(mism == 0, req, "mismatched bits", mism, 0);
  endtask

  task automatic run_full(input string req, input int len, input bit pad,
                          input bit nofcs, input int seed);
    clear_obs();
    fill(len, seed);
    buf_count = CW'(len);
    build_exp(len, pad, nofcs);
    issue(len, 3, pad, nofcs);
    wait_end(req, 20000);
    compare(req, exp_q.size());
    check(done_cnt == 1 && urun_cnt == 0, req, "done pulses", done_cnt, 1);
    check(done_cyc == last_bit_cyc + 1, "R9", "done cycle offset",
          done_cyc - last_bit_cyc, 1);
  endtask

  task automatic t_reset();
    clear_obs();
    bit_en = 1'b1; permit = 1'b1;
    repeat (20) step();
    check(got_q.size() == 0 && done_cnt == 0 && urun_cnt == 0, "R1",
          "activity after reset", got_q.size() + done_cnt + urun_cnt, 0);
  endtask

  task automatic t_basic();
    run_full("R3", 64, 1'b1, 1'b0, 1);
    check(exp_q.size() == 64 + 64 * 8 + 32, "R5", "expected length sanity",
          exp_q.size(), 64 + 64 * 8 + 32);
    run_full("R5", 100, 1'b0, 1'b0, 2);
  endtask

  task automatic t_pad();
    run_full("R7", 20, 1'b1, 1'b0, 3);
    check(got_q.size() == 64 + 64 * 8, "R7", "padded frame bits",
          got_q.size(), 64 + 64 * 8);
    run_full("R7", 20, 1'b0, 1'b0, 4);
    check(got_q.size() == 64 + 24 * 8, "R7", "unpadded frame bits",
          got_q.size(), 64 + 24 * 8);
    run_full("R6", 20, 1'b1, 1'b1, 5);
    check(got_q.size() == 64 + 60 * 8, "R6", "pad without fcs bits",
          got_q.size(), 64 + 60 * 8);
  endtask

  task automatic t_nofcs();
    run_full("R6", 70, 1'b0, 1'b1, 6);
    check(got_q.size() == 64 + 70 * 8, "R6", "no fcs bits", got_q.size(), 64 + 70 * 8);
  endtask

  task automatic t_half_rate();
    en_mode = 1;
    run_full("R4", 30, 1'b1, 1'b0, 7);
    check(en_viol == 0, "R4", "bits without enable", en_viol, 0);
    en_mode = 0;
  endtask

  task automatic t_gate(input int len, input int thr, input int thr_bytes, input int seed);
    clear_obs();
    fill(len, seed);
    build_exp(len, 1'b0, 1'b0);
    buf_count = CW'(thr_bytes - 1);
    issue(len, thr, 1'b0, 1'b0);
    repeat (30) step();
    check(got_q.size() == 0, "R2", "start below threshold", got_q.size(), 0);
    buf_count = CW'(thr_bytes);
    repeat (3) step();
    check(got_q.size() > 0, "R2", "start at threshold", got_q.size(), 1);
    buf_count = CW'(len);
    wait_end("R2", 20000);
    compare("R2", exp_q.size());
  endtask

  task automatic t_permit();
    clear_obs();
    fill(50, 8);
    build_exp(50, 1'b0, 1'b0);
    buf_count = CW'(50);
    permit = 1'b0;
    issue(50, 0, 1'b0, 1'b0);
    repeat (30) step();
    check(got_q.size() == 0, "R2", "start without permit", got_q.size(), 0);
    permit = 1'b1;
    wait_end("R2", 5000);
    compare("R2", exp_q.size());
  endtask

  task automatic t_drip();
    clear_obs();
    fill(80, 9);
    build_exp(80, 1'b0, 1'b0);
    buf_count = CW'(5);
    drip = 1;
    issue(80, 0, 1'b0, 1'b0);
    wait_end("R8", 5000);
    drip = 0;
    check(urun_cnt == 0, "R8", "underrun on just-in-time byte", urun_cnt, 0);
    compare("R8", exp_q.size());
  endtask

  task automatic t_underrun();
    int mism = 0;
    clear_obs();
    fill(100, 10);
    build_exp(100, 1'b0, 1'b0);
    buf_count = CW'(5);
    issue(100, 0, 1'b0, 1'b0);
    wait_end("R8", 5000);
    check(urun_cnt == 1 && done_cnt == 0, "R8", "underrun pulses", urun_cnt, 1);
    check(got_q.size() == 64 + 40, "R8", "bits before abort", got_q.size(), 104);
    for (int i = 0; i < got_q.size() && i < 104; i++) if (got_q[i] != exp_q[i]) mism++;
    check(mism == 0, "R8", "prefix mismatches", mism, 0);
    run_full("R8", 40, 1'b1, 1'b0, 11);
  endtask

  task automatic t_busy_cmd();
    clear_obs();
    fill(80, 12);
    build_exp(80, 1'b0, 1'b0);
    buf_count = CW'(80);
    issue(80, 3, 1'b0, 1'b0);
    while (got_q.size() < 100) step();
    cmd_len = CW'(10); cmd_pad = 1'b1; cmd_nofcs = 1'b1; cmd_valid = 1'b1;
    step();
    cmd_valid = 1'b0;
    wait_end("R10", 5000);
    compare("R10", exp_q.size());
    clear_obs();
    repeat (300) step();
    check(got_q.size() == 0 && done_cnt == 0, "R10", "late start from ignored command",
          got_q.size(), 0);
  endtask

  task automatic t_max();
    run_full("R11", 1514, 1'b0, 1'b0, 13);
    check(got_q.size() == 64 + 1518 * 8, "R11", "maximum frame bits",
          got_q.size(), 64 + 1518 * 8);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clear_obs();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_basic();
    t_pad();
    t_nofcs();
    t_half_rate();
    t_gate(400, 1, 381, 14);
    t_gate(100, 3, 100, 15);
    t_gate(1200, 2, 1021, 16);
    t_gate(64, 0, 5, 17);
    t_permit();
    t_drip();
    t_underrun();
    t_busy_cmd();
    t_max();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule